// File: doc/BRIEF.md
# Per-Pin Vector Drive Formatter and Response Comparator

This block holds the per-vector logic of one tester channel. Each vector begins with a strobe that carries a symbol. The symbol can ask the channel to drive a level, to release the pin, or to expect a response from the device. It can also repeat or invert the previous vector. The channel applies its selected drive format using the edge strobes of the active timing set. It produces a registered drive-data bit and a registered drive-enable bit, which go to the analog pin driver.

On the receive side, the channel takes the two comparator bits from the pin electronics. It judges them against the expected symbol in one of four capture styles. It then reports one pass/fail result per vector, one cycle after the closing window edge.

The timing-set generator and the analog circuits lie outside this block. Phase and window edges arrive as single-cycle strobes. Per-channel configuration selects which phase strobe asserts the data, which phase strobe returns it, and which window strobes open and close the compare window.

Top module: `chan_fmt_cmp`

## Requirements
- R1: While reset is active, and directly after it, `drv_en`, `drv_data`, `fail_vld` and `fail` are all 0.
- R2: Symbols are encoded as follows: 0 drive low, 1 drive high, 2 release (high-Z), 3 expect 0, 4 expect 1, 5 expect between-states, 6 expect mask, 7 keep last, 8 toggle last, and 9 to 15 act as expect mask. On the cycle after the phase strobe picked by `asrt_sel`, a drive symbol sets `drv_en`=1 and `drv_data` to its level, and every other symbol sets `drv_en`=0. A phase strobe that is not selected has no effect.
- R3: Format codes 1 (return-to-one) and 2 (return-to-zero) work as follows for drive symbols. The cycle after the vector strobe shows the return level (1 or 0) with `drv_en`=1. The cycle after the strobe picked by `ret_sel` shows the return level again.
- R4: Format code 3 (return-to-high-Z) sets `drv_en`=0 after the vector strobe and after the return strobe. The drive is enabled only between the assert and return edges.
- R5: Format code 5 (surround-by-complement) drives the complement of the data after the vector strobe and after the return strobe. It drives the data between the assert and return edges.
- R6: Format code 4 (return-to-complement) keeps the previous output after the vector strobe. It drives the data at the assert edge and the complement at the return edge.
- R7: Format code 0 (non-return) changes `drv_data`/`drv_en` only at the assert edge. The vector strobe and the return strobe leave them unchanged.
- R8: Keep-last repeats the previous vector's resolved symbol. Toggle-last inverts it: drive low and drive high swap, and expect 0 and expect 1 swap.
- R9: A sample reads as 1 when `cmp_hi`=1. It reads as 0 when both comparator bits are 0, and as between-states when `cmp_hi`=0 and `cmp_lo`=1. Capture mode 1 judges the sample taken at the opening window strobe (picked by `open_sel`). Capture mode 2 judges the sample taken at the closing window strobe (picked by `close_sel`).
- R10: In capture mode 3, the vector fails if any sample from the opening strobe to the closing strobe, both included, misses the expectation. It also fails if the comparator pair changes within that span.
- R11: `fail_vld` pulses for exactly the one cycle after each closing window strobe, and `fail` can be 1 only in that cycle.
- R12: `fail` stays 0 in three cases: capture mode 0 is selected, the symbol is an expect mask (or an unused code), or the symbol is not an expect symbol.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_sel | input | 3 | Drive format code |
| cap_mode | input | 2 | Capture style: 0 mask, 1 open edge, 2 close edge, 3 whole window |
| asrt_sel | input | $clog2(N_PH) | Phase strobe used as the assert edge |
| ret_sel | input | $clog2(N_PH) | Phase strobe used as the return edge |
| open_sel | input | $clog2(N_WIN) | Window strobe used as the opening edge |
| close_sel | input | $clog2(N_WIN) | Window strobe used as the closing edge |
| vec_vld | input | 1 | Start-of-vector strobe |
| vec_sym | input | 4 | Vector symbol, valid with `vec_vld` |
| ph_strb | input | N_PH | Phase edge strobes |
| win_strb | input | N_WIN | Window edge strobes |
| cmp_hi | input | 1 | High comparator: pin above the high threshold |
| cmp_lo | input | 1 | Low comparator: pin above the low threshold |
| drv_data | output | 1 | Drive level to the pin driver |
| drv_en | output | 1 | Driver enable (0 = high-Z) |
| fail_vld | output | 1 | Per-vector result valid pulse |
| fail | output | 1 | Per-vector compare failure |

## Verification
The bench builds the block with its defaults of four phase strobes and four window strobes. It wires asserts to phase 0, returns to phase 2, opening to window 1 and closing to window 3. This leaves phase 1 free as an unselected strobe, which shows that an edge outside the selection is ignored. Running the six formats back to back shows the hold behaviour of non-return and return-to-complement, because each vector's leading state follows from the one before it. In window capture, a comparator pair that changes while still meeting the expectation separates the whole-window style from the opening-edge style.

// File: rtl/chan_pkg.sv
package chan_pkg;

  localparam int SYM_W = 4;
  localparam int FMT_W = 3;
  localparam int CAP_W = 2;

  localparam logic [SYM_W-1:0] SYM_DRV_LO   = 4'd0;
  localparam logic [SYM_W-1:0] SYM_DRV_HI   = 4'd1;
  localparam logic [SYM_W-1:0] SYM_DRV_Z    = 4'd2;
  localparam logic [SYM_W-1:0] SYM_EXP_0    = 4'd3;
  localparam logic [SYM_W-1:0] SYM_EXP_1    = 4'd4;
  localparam logic [SYM_W-1:0] SYM_EXP_MID  = 4'd5;
  localparam logic [SYM_W-1:0] SYM_EXP_MASK = 4'd6;
  localparam logic [SYM_W-1:0] SYM_KEEP     = 4'd7;
  localparam logic [SYM_W-1:0] SYM_TOGGLE   = 4'd8;

  localparam logic [FMT_W-1:0] FMT_NR  = 3'd0;
  localparam logic [FMT_W-1:0] FMT_RO  = 3'd1;
  localparam logic [FMT_W-1:0] FMT_RZ  = 3'd2;
  localparam logic [FMT_W-1:0] FMT_RHZ = 3'd3;
  localparam logic [FMT_W-1:0] FMT_RC  = 3'd4;
  localparam logic [FMT_W-1:0] FMT_SBC = 3'd5;

  localparam logic [CAP_W-1:0] CAP_MASK  = 2'd0;
  localparam logic [CAP_W-1:0] CAP_OPEN  = 2'd1;
  localparam logic [CAP_W-1:0] CAP_CLOSE = 2'd2;
  localparam logic [CAP_W-1:0] CAP_WIN   = 2'd3;

  function automatic logic sym_is_drive(input logic [SYM_W-1:0] s);
    return (s == SYM_DRV_LO) || (s == SYM_DRV_HI);
  endfunction

  function automatic logic sym_is_expect(input logic [SYM_W-1:0] s);
    return (s == SYM_EXP_0) || (s == SYM_EXP_1) || (s == SYM_EXP_MID);
  endfunction

  // True when the comparator pair meets the expectation of symbol s.
  function automatic logic sym_match(input logic [SYM_W-1:0] s,
                                     input logic hi, input logic lo);
    logic r;
    case (s)
      SYM_EXP_1:   r = hi;
      SYM_EXP_0:   r = !hi && !lo;
      SYM_EXP_MID: r = !hi && lo;
      default:     r = 1'b1;
    endcase
    return r;
  endfunction

  // Inverted symbol used by toggle-last.
  function automatic logic [SYM_W-1:0] sym_flip(input logic [SYM_W-1:0] s);
    logic [SYM_W-1:0] r;
    case (s)
      SYM_DRV_LO: r = SYM_DRV_HI;
      SYM_DRV_HI: r = SYM_DRV_LO;
      SYM_EXP_0:  r = SYM_EXP_1;
      SYM_EXP_1:  r = SYM_EXP_0;
      default:    r = s;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/chan_rst_sync.sv
module chan_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/chan_edge_pick.sv
module chan_edge_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0]         strb,
  input  logic [$clog2(N)-1:0] sel,
  output logic                 hit
);
  localparam int SW = $clog2(N);

  logic [N-1:0] gated;

  for (genvar i = 0; i < N; i++) begin : g_gate
    assign gated[i] = strb[i] & (sel == SW'(i));
  end

  assign hit = |gated;
endmodule

// File: rtl/chan_sym_track.sv
module chan_sym_track
  import chan_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vec_vld,
  input  logic [SYM_W-1:0] vec_sym,
  output logic [SYM_W-1:0] eff_sym
);
  logic [SYM_W-1:0] cur_q;
  logic [SYM_W-1:0] res_sym;

  always_comb begin
    case (vec_sym)
      SYM_KEEP:   res_sym = cur_q;
      SYM_TOGGLE: res_sym = sym_flip(cur_q);
      SYM_DRV_LO, SYM_DRV_HI, SYM_DRV_Z,
      SYM_EXP_0, SYM_EXP_1, SYM_EXP_MID,
      SYM_EXP_MASK: res_sym = vec_sym;
      default:    res_sym = SYM_EXP_MASK;
    endcase
    eff_sym = vec_vld ? res_sym : cur_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cur_q <= SYM_DRV_Z;
    else if (vec_vld) cur_q <= res_sym;
  end
endmodule

// File: rtl/chan_drv_fmt.sv
module chan_drv_fmt
  import chan_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FMT_W-1:0] fmt_sel,
  input  logic [SYM_W-1:0] eff_sym,
  input  logic             vec_vld,
  input  logic             asrt_hit,
  input  logic             ret_hit,
  output logic             drv_data,
  output logic             drv_en
);
  logic data_q, en_q;
  logic data_d, en_d;
  logic is_drv, lvl;

  always_comb begin
    is_drv = sym_is_drive(eff_sym);
    lvl    = (eff_sym == SYM_DRV_HI);
    data_d = data_q;
    en_d   = en_q;
    if (ret_hit) begin
      // return edge has priority over a coincident assert edge
      if (is_drv) begin
        case (fmt_sel)
          FMT_RO:  begin data_d = 1'b1; en_d = 1'b1; end
          FMT_RZ:  begin data_d = 1'b0; en_d = 1'b1; end
          FMT_RHZ: en_d = 1'b0;
          FMT_RC,
          FMT_SBC: begin data_d = !lvl; en_d = 1'b1; end
          default: ;
        endcase
      end
    end else if (asrt_hit) begin
      if (is_drv) begin
        data_d = lvl;
        en_d   = 1'b1;
      end else begin
        en_d   = 1'b0;
      end
    end else if (vec_vld) begin
      // leading state of a new vector
      if (is_drv) begin
        case (fmt_sel)
          FMT_RO:  begin data_d = 1'b1; en_d = 1'b1; end
          FMT_RZ:  begin data_d = 1'b0; en_d = 1'b1; end
          FMT_RHZ: en_d = 1'b0;
          FMT_SBC: begin data_d = !lvl; en_d = 1'b1; end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      data_q <= data_d;
      en_q   <= en_d;
    end
  end

  assign drv_data = data_q;
  assign drv_en   = en_q;
endmodule

// File: rtl/chan_cmp_win.sv
module chan_cmp_win
  import chan_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CAP_W-1:0] cap_mode,
  input  logic [SYM_W-1:0] eff_sym,
  input  logic             vec_vld,
  input  logic             open_hit,
  input  logic             close_hit,
  input  logic             cmp_hi,
  input  logic             cmp_lo,
  output logic             fail_vld,
  output logic             fail
);
  logic       err_q, err_d, err_base;
  logic [1:0] ref_q, ref_d, pair;
  logic       won_q, won_d;
  logic       done_q, done_d;
  logic       fail_q, fail_d;
  logic       chk, ok;

  always_comb begin
    pair     = {cmp_hi, cmp_lo};
    chk      = sym_is_expect(eff_sym) && (cap_mode != CAP_MASK);
    ok       = sym_match(eff_sym, cmp_hi, cmp_lo);
    err_base = vec_vld ? 1'b0 : err_q;
    err_d    = err_base;
    ref_d    = ref_q;
    case (cap_mode)
      CAP_OPEN:  if (open_hit)  err_d = !ok;
      CAP_CLOSE: if (close_hit) err_d = !ok;
      CAP_WIN: begin
        if (open_hit) begin
          err_d = !ok;
          ref_d = pair;
        end else if (won_q) begin
          err_d = err_base | !ok | (pair != ref_q);
        end
      end
      default:   err_d = 1'b0;
    endcase
    if (close_hit)     won_d = 1'b0;
    else if (open_hit) won_d = 1'b1;
    else               won_d = won_q;
    done_d = close_hit;
    fail_d = close_hit & chk & err_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= 1'b0;
      ref_q  <= 2'b00;
      won_q  <= 1'b0;
      done_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      err_q  <= err_d;
      ref_q  <= ref_d;
      won_q  <= won_d;
      done_q <= done_d;
      fail_q <= fail_d;
    end
  end

  assign fail_vld = done_q;
  assign fail     = fail_q;
endmodule

// File: rtl/chan_fmt_cmp.sv
module chan_fmt_cmp
  import chan_pkg::*;
#(
  parameter int N_PH  = 4,
  parameter int N_WIN = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [2:0]               fmt_sel,
  input  logic [1:0]               cap_mode,
  input  logic [$clog2(N_PH)-1:0]  asrt_sel,
  input  logic [$clog2(N_PH)-1:0]  ret_sel,
  input  logic [$clog2(N_WIN)-1:0] open_sel,
  input  logic [$clog2(N_WIN)-1:0] close_sel,
  input  logic                     vec_vld,
  input  logic [3:0]               vec_sym,
  input  logic [N_PH-1:0]          ph_strb,
  input  logic [N_WIN-1:0]         win_strb,
  input  logic                     cmp_hi,
  input  logic                     cmp_lo,
  output logic                     drv_data,
  output logic                     drv_en,
  output logic                     fail_vld,
  output logic                     fail
);
  logic             rst_sync_n;
  logic             asrt_hit, ret_hit, open_hit, close_hit;
  logic [SYM_W-1:0] eff_sym;

  chan_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  chan_edge_pick #(.N(N_PH)) u_pick_asrt (
    .strb(ph_strb), .sel(asrt_sel), .hit(asrt_hit)
  );
  chan_edge_pick #(.N(N_PH)) u_pick_ret (
    .strb(ph_strb), .sel(ret_sel), .hit(ret_hit)
  );
  chan_edge_pick #(.N(N_WIN)) u_pick_open (
    .strb(win_strb), .sel(open_sel), .hit(open_hit)
  );
  chan_edge_pick #(.N(N_WIN)) u_pick_close (
    .strb(win_strb), .sel(close_sel), .hit(close_hit)
  );

  chan_sym_track u_sym (
    .clk(clk), .rst_n(rst_sync_n), .vec_vld(vec_vld),
    .vec_sym(vec_sym), .eff_sym(eff_sym)
  );

  chan_drv_fmt u_drv (
    .clk(clk), .rst_n(rst_sync_n), .fmt_sel(fmt_sel), .eff_sym(eff_sym),
    .vec_vld(vec_vld), .asrt_hit(asrt_hit), .ret_hit(ret_hit),
    .drv_data(drv_data), .drv_en(drv_en)
  );

  chan_cmp_win u_cmp (
    .clk(clk), .rst_n(rst_sync_n), .cap_mode(cap_mode), .eff_sym(eff_sym),
    .vec_vld(vec_vld), .open_hit(open_hit), .close_hit(close_hit),
    .cmp_hi(cmp_hi), .cmp_lo(cmp_lo), .fail_vld(fail_vld), .fail(fail)
  );
endmodule

// File: rtl/chan_fmt_cmp_chk.sv
module chan_fmt_cmp_chk
  import chan_pkg::*;
(
  input logic       clk,
  input logic       rst_sync_n,
  input logic [2:0] fmt_sel,
  input logic [1:0] cap_mode,
  input logic       vec_vld,
  input logic [3:0] vec_sym,
  input logic       asrt_hit,
  input logic       ret_hit,
  input logic       close_hit,
  input logic       drv_data,
  input logic       drv_en,
  input logic       fail_vld,
  input logic       fail
);
  // R11: a failure is only reported together with its valid pulse
  p_fail_qual_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fail |-> fail_vld);

  // R11: the result follows the closing edge by one cycle
  p_vld_after_close_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    close_hit |=> fail_vld);

  // R11: no result without a closing edge
  p_no_stray_vld_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !close_hit |=> !fail_vld);

  // R12: the masked capture mode never fails
  p_mask_mode_r12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (close_hit && cap_mode == CAP_MASK) |=> !fail);

  // R7: non-return output moves only at the assert edge
  p_nr_hold_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fmt_sel == FMT_NR && !asrt_hit) |=> ($stable(drv_data) && $stable(drv_en)));

  // R2: a release symbol turns the driver off at its assert edge
  p_z_release_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (vec_vld && vec_sym == SYM_DRV_Z && asrt_hit && !ret_hit) |=> !drv_en);
endmodule

bind chan_fmt_cmp chan_fmt_cmp_chk u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .fmt_sel(fmt_sel), .cap_mode(cap_mode),
  .vec_vld(vec_vld), .vec_sym(vec_sym), .asrt_hit(asrt_hit), .ret_hit(ret_hit),
  .close_hit(close_hit), .drv_data(drv_data), .drv_en(drv_en),
  .fail_vld(fail_vld), .fail(fail)
);

// File: tb/chan_fmt_cmp_tb_top.sv
module chan_fmt_cmp_tb_top;
  localparam int CLK_P = 10;

  logic       clk;
  logic       rst_n;
  logic [2:0] fmt_sel;
  logic [1:0] cap_mode;
  logic [1:0] asrt_sel, ret_sel, open_sel, close_sel;
  logic       vec_vld;
  logic [3:0] vec_sym;
  logic [3:0] ph_strb, win_strb;
  logic       cmp_hi, cmp_lo;
  logic       drv_data, drv_en, fail_vld, fail;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  chan_fmt_cmp dut_i (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .cap_mode(cap_mode),
    .asrt_sel(asrt_sel), .ret_sel(ret_sel), .open_sel(open_sel),
    .close_sel(close_sel), .vec_vld(vec_vld), .vec_sym(vec_sym),
    .ph_strb(ph_strb), .win_strb(win_strb), .cmp_hi(cmp_hi), .cmp_lo(cmp_lo),
    .drv_data(drv_data), .drv_en(drv_en), .fail_vld(fail_vld), .fail(fail)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // One clock: drive at the falling edge, sample a quarter period after the rising edge.
  task automatic cyc(input logic v, input logic [3:0] s, input logic [3:0] ph,
                     input logic [3:0] wn, input logic hi, input logic lo);
    @(negedge clk);
    vec_vld = v; vec_sym = s; ph_strb = ph; win_strb = wn;
    cmp_hi = hi; cmp_lo = lo;
    @(posedge clk);
    #(CLK_P/4);
    vec_vld = 1'b0; ph_strb = '0; win_strb = '0;
  endtask

  task automatic chk_pin(input string req, input string what,
                         input logic e_en, input logic e_d);
    check(req, {what, " en"}, drv_en, e_en);
    if (e_en) check(req, {what, " data"}, drv_data, e_d);
  endtask

  // Drive vector: strobe, assert on phase 0, unselected phase 1, return on phase 2.
  task automatic drv_case(input string req, input logic [2:0] fmt, input logic [3:0] s,
                          input logic pe, input logic pd, input logic ae, input logic ad,
                          input logic re, input logic rd);
    fmt_sel = fmt;
    cyc(1'b1, s, 4'b0000, 4'b0000, 1'b0, 1'b0);
    chk_pin(req, "lead", pe, pd);
    cyc(1'b0, 4'd0, 4'b0001, 4'b0000, 1'b0, 1'b0);
    chk_pin(req, "assert", ae, ad);
    cyc(1'b0, 4'd0, 4'b0010, 4'b0000, 1'b0, 1'b0);
    chk_pin("R2", "unselected phase", ae, ad);
    cyc(1'b0, 4'd0, 4'b0100, 4'b0000, 1'b0, 1'b0);
    chk_pin(req, "return", re, rd);
  endtask

  // Compare vector: open on window 1, middle cycle, close on window 3.
  task automatic cmp_case(input string req, input logic [1:0] mode, input logic [3:0] s,
                          input logic [2:0] hi, input logic [2:0] lo, input logic e_fail);
    cap_mode = mode;
    cyc(1'b1, s, 4'b0000, 4'b0000, 1'b0, 1'b0);
    cyc(1'b0, 4'd0, 4'b0000, 4'b0010, hi[0], lo[0]);
    cyc(1'b0, 4'd0, 4'b0000, 4'b0000, hi[1], lo[1]);
    check("R11", "no result before close", fail_vld, 1'b0);
    cyc(1'b0, 4'd0, 4'b0000, 4'b1000, hi[2], lo[2]);
    check("R11", "result valid after close", fail_vld, 1'b1);
    check(req, "fail", fail, e_fail);
    cyc(1'b0, 4'd0, 4'b0000, 4'b0000, 1'b0, 1'b0);
    check("R11", "valid is one cycle", fail_vld, 1'b0);
    check("R11", "fail cleared", fail, 1'b0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    fmt_sel = 3'd0; cap_mode = 2'd0;
    asrt_sel = 2'd0; ret_sel = 2'd2; open_sel = 2'd1; close_sel = 2'd3;
    vec_vld = 1'b0; vec_sym = 4'd0; ph_strb = '0; win_strb = '0;
    cmp_hi = 1'b0; cmp_lo = 1'b0;
    repeat (3) @(posedge clk);
    #(CLK_P/4);
    check("R1", "en in reset", drv_en, 1'b0);
    check("R1", "data in reset", drv_data, 1'b0);
    check("R1", "fail_vld in reset", fail_vld, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #(CLK_P/4);
    check("R1", "en after reset", drv_en, 1'b0);
    check("R1", "data after reset", drv_data, 1'b0);
    check("R1", "fail after reset", fail, 1'b0);
  endtask

  task automatic t_return_levels;
    drv_case("R3", 3'd2, 4'd1, 1, 0, 1, 1, 1, 0);
    drv_case("R3", 3'd1, 4'd0, 1, 1, 1, 0, 1, 1);
  endtask

  task automatic t_return_hiz;
    drv_case("R4", 3'd3, 4'd1, 0, 0, 1, 1, 0, 0);
  endtask

  task automatic t_surround;
    drv_case("R5", 3'd5, 4'd1, 1, 0, 1, 1, 1, 0);
    drv_case("R5", 3'd5, 4'd0, 1, 1, 1, 0, 1, 1);
  endtask

  task automatic t_ret_compl;
    drv_case("R6", 3'd4, 4'd1, 1, 1, 1, 1, 1, 0);
    drv_case("R6", 3'd4, 4'd0, 1, 0, 1, 0, 1, 1);
  endtask

  task automatic t_non_return;
    drv_case("R7", 3'd0, 4'd0, 1, 1, 1, 0, 1, 0);
    drv_case("R7", 3'd0, 4'd1, 1, 0, 1, 1, 1, 1);
  endtask

  task automatic t_keep_toggle;
    drv_case("R8", 3'd0, 4'd7, 1, 1, 1, 1, 1, 1);
    drv_case("R8", 3'd0, 4'd8, 1, 1, 1, 0, 1, 0);
    drv_case("R8", 3'd0, 4'd8, 1, 0, 1, 1, 1, 1);
  endtask

  task automatic t_release;
    drv_case("R2", 3'd0, 4'd2, 1, 1, 0, 0, 0, 0);
    drv_case("R2", 3'd2, 4'd4, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_edges;
    cmp_case("R9", 2'd1, 4'd4, 3'b001, 3'b000, 1'b0);
    cmp_case("R9", 2'd1, 4'd4, 3'b110, 3'b000, 1'b1);
    cmp_case("R9", 2'd2, 4'd3, 3'b011, 3'b000, 1'b0);
    cmp_case("R9", 2'd2, 4'd3, 3'b100, 3'b000, 1'b1);
    cmp_case("R9", 2'd1, 4'd4, 3'b111, 3'b101, 1'b0);
  endtask

  task automatic t_window;
    cmp_case("R10", 2'd3, 4'd4, 3'b111, 3'b111, 1'b0);
    cmp_case("R10", 2'd3, 4'd4, 3'b101, 3'b000, 1'b1);
    cmp_case("R10", 2'd3, 4'd5, 3'b000, 3'b111, 1'b0);
    cmp_case("R10", 2'd3, 4'd5, 3'b000, 3'b101, 1'b1);
    cmp_case("R10", 2'd3, 4'd4, 3'b111, 3'b101, 1'b1);
  endtask

  task automatic t_expect_toggle;
    cmp_case("R8", 2'd3, 4'd4, 3'b111, 3'b111, 1'b0);
    cmp_case("R8", 2'd3, 4'd8, 3'b111, 3'b111, 1'b1);
    cmp_case("R8", 2'd3, 4'd8, 3'b111, 3'b111, 1'b0);
  endtask

  task automatic t_masked;
    cmp_case("R12", 2'd0, 4'd4, 3'b000, 3'b000, 1'b0);
    cmp_case("R12", 2'd3, 4'd6, 3'b000, 3'b000, 1'b0);
    cmp_case("R12", 2'd3, 4'd1, 3'b000, 3'b000, 1'b0);
    cmp_case("R12", 2'd3, 4'd15, 3'b000, 3'b000, 1'b0);
  endtask

  initial begin
    t_reset();
    t_return_levels();
    t_return_hiz();
    t_surround();
    t_ret_compl();
    t_non_return();
    t_keep_toggle();
    t_release();
    t_edges();
    t_window();
    t_expect_toggle();
    t_masked();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule